// File: doc/BRIEF.md
# Fully Associative Sv32 Translation Cache with Tree Pseudo-LRU

This block is a small, fully associative cache of recent Sv32 address translations. Each entry keeps a tag and a 32-bit page table entry. The tag holds two 10-bit virtual page number halves, an address-space identifier, a superpage flag and a valid bit. A lookup presents an access strobe, an address-space identifier and a 32-bit virtual address. In the same cycle the block answers with a hit flag, the stored page table entry and the superpage flag of the matching entry.

An update port writes a fresh translation into the entry that a binary-tree pseudo-LRU picks as the victim. A flush port carries the four address-fence variants, chosen by two qualifier bits: whether a virtual address is given and whether an address-space identifier is given. Each hit promotes the matching entry to most recently used, and so does each write. The block does not check permissions, does not form the physical address and does not walk page tables.

Top module: `sv32_assoc_tlb`

## Requirements
- R1: With the strobe high, an entry hits when all of the following hold: it is valid, its upper page half equals vaddr[31:22], its ASID equals the lookup ASID or its global bit (PTE bit 5) is set, and its lower page half equals vaddr[21:12] or its superpage flag is set. With the strobe low, the hit output is 0.
- R2: On a hit, the same cycle drives the stored PTE and the stored superpage flag. The PTE layout is: PPN in [31:10], software bits in [9:8], then D=7, A=6, G=5, U=4, X=3, W=2, R=1, V=0. Offset bits [11:0] do not take part in matching.
- R3: An accepted update writes its page number (upper half in [19:10]) and its ASID, superpage flag and PTE into the current victim entry. It marks the entry valid only when PTE bit 0 is 1.
- R4: The replacement state is ENTRIES-1 node bits in an array, ordered root first and then level by level, left to right. A node value of 0 means the left subtree and 1 means the right subtree. The victim is the entry whose index bits, MSB first, equal the node values along its path. A promotion sets each node on the entry's path to the inverse of the matching index bit. An accepted update promotes the entry it wrote. Otherwise a lookup hit promotes the entry that hit.
- R5: A flush with neither qualifier invalidates every entry.
- R6: A flush with only the address qualifier invalidates every entry whose page matches the flush address, for any ASID and any global bit. An entry's page matches when its upper half is equal and its lower half is equal or it is a superpage.
- R7: A flush with only the ASID qualifier invalidates the non-global entries with that ASID. Global entries survive.
- R8: A flush with both qualifiers invalidates the non-global entries whose page matches the address and whose ASID matches. All other entries survive.
- R9: A flush and an update in the same cycle: the flush wins and the update is dropped.
- R10: The asynchronous active-low reset clears every valid bit and every replacement node, so the first victim after reset is entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_access | input | 1 | Lookup strobe |
| lk_asid | input | ASID_W | Lookup address-space identifier |
| lk_vaddr | input | 32 | Lookup virtual address |
| lk_hit | output | 1 | Lookup hit |
| lk_pte | output | 32 | PTE of the hitting entry, zero on a miss |
| lk_big | output | 1 | Hitting entry is a 4 MiB superpage |
| up_valid | input | 1 | Write a new translation |
| up_vpn | input | 20 | Virtual page number of the new translation |
| up_asid | input | ASID_W | ASID of the new translation |
| up_big | input | 1 | New translation is a superpage |
| up_pte | input | 32 | PTE of the new translation |
| fl_valid | input | 1 | Flush strobe |
| fl_use_va | input | 1 | Flush is restricted to an address |
| fl_use_asid | input | 1 | Flush is restricted to an ASID |
| fl_vaddr | input | 32 | Flush virtual address |
| fl_asid | input | ASID_W | Flush ASID |

## Verification
The bench builds the block with its defaults: eight entries and a 9-bit ASID. This gives a three-level replacement tree, so a victim depends on three node bits. The promotions from the bench's hits make the eviction order differ from plain round robin. With a 9-bit ASID the bench can make entries that share a page but belong to different address spaces, and global entries under one ASID that another ASID looks up. Together these cover every flush variant. A bench model of the tree, walked by heap indexing, predicts which entry each update evicts. The bench then scans every translation written so far.

// File: rtl/tlbp_pkg.sv
package tlbp_pkg;
  localparam int VPN_W = 10;
  localparam int PN_W  = 2 * VPN_W;

  typedef struct packed {
    logic [21:0] ppn;
    logic [1:0]  sw;
    logic        d;
    logic        a;
    logic        g;
    logic        u;
    logic        x;
    logic        w;
    logic        r;
    logic        v;
  } pte_t;

  // Page match used both by lookup and by address-qualified flush.
  function automatic logic page_hit(input logic [VPN_W-1:0] hi,
                                    input logic [VPN_W-1:0] lo,
                                    input logic             big,
                                    input logic [PN_W-1:0]  pn);
    return (hi == pn[PN_W-1:VPN_W]) && (big || (lo == pn[VPN_W-1:0]));
  endfunction
endpackage

// File: rtl/tlb_entry_cmp.sv
module tlb_entry_cmp
  import tlbp_pkg::*;
#(
  parameter int ASID_W = 9
) (
  input  logic                 vld,
  input  logic [VPN_W-1:0]     hi,
  input  logic [VPN_W-1:0]     lo,
  input  logic                 big,
  input  logic                 glob,
  input  logic [ASID_W-1:0]    asid,
  input  logic [ASID_W-1:0]    lk_asid,
  input  logic [PN_W-1:0]      lk_pn,
  input  logic                 fl_use_va,
  input  logic                 fl_use_asid,
  input  logic [PN_W-1:0]      fl_pn,
  input  logic [ASID_W-1:0]    fl_asid,
  output logic                 hit,
  output logic                 kill
);
  logic lk_page, fl_page, fl_space;

  assign lk_page  = page_hit(hi, lo, big, lk_pn);
  assign fl_page  = page_hit(hi, lo, big, fl_pn);
  assign fl_space = !glob && (asid == fl_asid);

  assign hit = vld && lk_page && (glob || (asid == lk_asid));

  always_comb begin
    unique case ({fl_use_va, fl_use_asid})
      2'b00:   kill = 1'b1;
      2'b10:   kill = fl_page;
      2'b01:   kill = fl_space;
      default: kill = fl_page && fl_space;
    endcase
  end
endmodule

// File: rtl/plru_tree.sv
module plru_tree #(
  parameter int N = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 touch,
  input  logic [$clog2(N)-1:0] touch_idx,
  output logic [$clog2(N)-1:0] victim
);
  localparam int LG    = $clog2(N);
  localparam int NODES = N - 1;

  logic [NODES-1:0] node_q;

  // Point every node on the path of idx away from it.
  function automatic logic [NODES-1:0] promote(input logic [NODES-1:0] s,
                                               input logic [LG-1:0]    idx);
    logic [NODES-1:0] r;
    int pos;
    r = s;
    for (int l = 0; l < LG; l++) begin
      pos    = (1 << l) - 1 + int'(idx >> (LG - l));
      r[pos] = ~idx[LG-1-l];
    end
    return r;
  endfunction

  // Follow the node values from the root down to a leaf.
  function automatic logic [LG-1:0] pick(input logic [NODES-1:0] s);
    logic [LG-1:0] v;
    int pos;
    v   = '0;
    pos = 0;
    for (int l = 0; l < LG; l++) begin
      v[LG-1-l] = s[pos];
      pos       = 2 * pos + 1 + int'(s[pos]);
    end
    return v;
  endfunction

  assign victim = pick(node_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     node_q <= '0;
    else if (touch) node_q <= promote(node_q, touch_idx);
  end

  // R4: an entry just promoted is never the next victim.
  p_promoted_not_victim_r4: assert property (@(posedge clk) disable iff (!rst_n)
    touch |=> (victim != $past(touch_idx)));
endmodule

// File: rtl/sv32_assoc_tlb.sv
module sv32_assoc_tlb
  import tlbp_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int ASID_W  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_access,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic [31:0]       lk_vaddr,
  output logic              lk_hit,
  output logic [31:0]       lk_pte,
  output logic              lk_big,
  input  logic              up_valid,
  input  logic [PN_W-1:0]   up_vpn,
  input  logic [ASID_W-1:0] up_asid,
  input  logic              up_big,
  input  logic [31:0]       up_pte,
  input  logic              fl_valid,
  input  logic              fl_use_va,
  input  logic              fl_use_asid,
  input  logic [31:0]       fl_vaddr,
  input  logic [ASID_W-1:0] fl_asid
);
  localparam int LG = $clog2(ENTRIES);
  typedef logic [LG-1:0] idx_t;

  logic [ENTRIES-1:0] valid_q, hit_vec, kill_vec, big_q;
  logic [VPN_W-1:0]   hi_q   [ENTRIES];
  logic [VPN_W-1:0]   lo_q   [ENTRIES];
  logic [ASID_W-1:0]  asid_q [ENTRIES];
  pte_t               pte_q  [ENTRIES];

  idx_t hit_idx, victim_idx, touch_idx;
  logic any_hit, upd_fire, touch;
  logic unused_ofs;

  assign unused_ofs = ^{lk_vaddr[11:0], fl_vaddr[11:0]};

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    tlb_entry_cmp #(.ASID_W(ASID_W)) u_cmp (
      .vld         (valid_q[i]),
      .hi          (hi_q[i]),
      .lo          (lo_q[i]),
      .big         (big_q[i]),
      .glob        (pte_q[i].g),
      .asid        (asid_q[i]),
      .lk_asid     (lk_asid),
      .lk_pn       (lk_vaddr[31:12]),
      .fl_use_va   (fl_use_va),
      .fl_use_asid (fl_use_asid),
      .fl_pn       (fl_vaddr[31:12]),
      .fl_asid     (fl_asid),
      .hit         (hit_vec[i]),
      .kill        (kill_vec[i])
    );

    // R7: an ASID-only flush leaves a valid global entry in place.
    p_global_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (fl_valid && fl_use_asid && !fl_use_va && valid_q[i] && pte_q[i].g)
        |=> valid_q[i]);
  end

  // Lowest-numbered hitting entry drives the outputs.
  always_comb begin
    hit_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hit_vec[i]) hit_idx = idx_t'(i);
    end
  end

  assign any_hit = |hit_vec;
  assign lk_hit  = lk_access && any_hit;
  assign lk_pte  = lk_hit ? pte_q[hit_idx] : '0;
  assign lk_big  = lk_hit && big_q[hit_idx];

  assign upd_fire  = up_valid && !fl_valid;
  assign touch     = upd_fire || lk_hit;
  assign touch_idx = upd_fire ? victim_idx : hit_idx;

  plru_tree #(.N(ENTRIES)) u_plru (
    .clk       (clk),
    .rst_n     (rst_n),
    .touch     (touch),
    .touch_idx (touch_idx),
    .victim    (victim_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        valid_q <= '0;
    else if (fl_valid) valid_q <= valid_q & ~kill_vec;
    else if (upd_fire) valid_q[victim_idx] <= up_pte[0];
  end

  always_ff @(posedge clk) begin
    if (upd_fire) begin
      hi_q[victim_idx]   <= up_vpn[PN_W-1:VPN_W];
      lo_q[victim_idx]   <= up_vpn[VPN_W-1:0];
      big_q[victim_idx]  <= up_big;
      asid_q[victim_idx] <= up_asid;
      pte_q[victim_idx]  <= pte_t'(up_pte);
    end
  end

  // R1: a reported hit always comes from a valid entry.
  p_hit_from_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> valid_q[hit_idx]);

  // R3: the written entry's valid bit follows the PTE V bit.
  p_update_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    upd_fire |=> (valid_q[$past(victim_idx)] == $past(up_pte[0])));

  // R5: an unqualified flush empties the cache.
  p_flush_all_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_valid && !fl_use_va && !fl_use_asid) |=> (valid_q == '0));

  // R9: no entry becomes valid in a flush cycle.
  p_flush_blocks_fill_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fl_valid |=> ((valid_q & ~$past(valid_q)) == '0));
endmodule

// File: tb/sv32_assoc_tlb_test.sv
module sv32_assoc_tlb_test;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lk_access = 0, up_valid = 0, up_big = 0, fl_valid = 0, fl_use_va = 0, fl_use_asid = 0;
  logic [8:0] lk_asid = 0, up_asid = 0, fl_asid = 0;
  logic [31:0] lk_vaddr = 0, up_pte = 0, fl_vaddr = 0;
  logic [19:0] up_vpn = 0;
  logic lk_hit, lk_big;
  logic [31:0] lk_pte;

  always #2.5 clk = ~clk;

  sv32_assoc_tlb uut (
    .clk(clk), .rst_n(rst_n), .lk_access(lk_access), .lk_asid(lk_asid), .lk_vaddr(lk_vaddr),
    .lk_hit(lk_hit), .lk_pte(lk_pte), .lk_big(lk_big), .up_valid(up_valid), .up_vpn(up_vpn),
    .up_asid(up_asid), .up_big(up_big), .up_pte(up_pte), .fl_valid(fl_valid),
    .fl_use_va(fl_use_va), .fl_use_asid(fl_use_asid), .fl_vaddr(fl_vaddr), .fl_asid(fl_asid));

  typedef struct { logic hit; logic [31:0] pte; logic big; string tag; } exp_t;
  exp_t q[$];
  int checks = 0, errors = 0;
  bit done = 0;

  // Reference model
  logic        m_val [N];
  logic [19:0] m_vpn [N];
  logic [8:0]  m_asid[N];
  logic        m_big [N];
  logic [31:0] m_pte [N];
  logic        m_node[N-1];
  logic [19:0] h_vpn[$];
  logic [8:0]  h_asid[$];

  function automatic logic [31:0] va(input logic [19:0] pn);
    return {pn, 12'h5A4};
  endfunction

  function automatic bit m_page(input int i, input logic [31:0] a);
    return m_vpn[i][19:10] == a[31:22] && (m_big[i] || m_vpn[i][9:0] == a[21:12]);
  endfunction

  function automatic int m_find(input logic [8:0] as, input logic [31:0] a);
    for (int i = 0; i < N; i++)
      if (m_val[i] && m_page(i, a) && (m_pte[i][5] || m_asid[i] == as)) return i;
    return -1;
  endfunction

  function automatic int m_victim();
    int n = 0, v = 0;
    for (int l = 0; l < 3; l++) begin
      v = v * 2 + int'(m_node[n]);
      n = 2 * n + 1 + int'(m_node[n]);
    end
    return v;
  endfunction

  task automatic m_touch(input int e);
    int n = 0, b;
    for (int l = 0; l < 3; l++) begin
      b = (e >> (2 - l)) & 1;
      m_node[n] = (b == 0);
      n = 2 * n + 1 + b;
    end
  endtask

  task automatic m_clear();
    for (int i = 0; i < N; i++) m_val[i] = 0;
    for (int i = 0; i < N - 1; i++) m_node[i] = 0;
  endtask

  task automatic cyc(input bit chk, input string tag, input bit acc, input logic [8:0] las,
                     input logic [31:0] la, input bit up, input logic [19:0] uvpn,
                     input logic [8:0] uas, input bit ubig, input logic [31:0] upte,
                     input bit fl, input bit fva, input bit fas, input logic [31:0] fa,
                     input logic [8:0] fasid);
    int h, v;
    exp_t e;
    @(negedge clk);
    lk_access = acc; lk_asid = las; lk_vaddr = la;
    up_valid = up; up_vpn = uvpn; up_asid = uas; up_big = ubig; up_pte = upte;
    fl_valid = fl; fl_use_va = fva; fl_use_asid = fas; fl_vaddr = fa; fl_asid = fasid;
    h = acc ? m_find(las, la) : -1;
    if (chk) begin
      e.hit = (h >= 0); e.tag = tag;
      e.pte = (h >= 0) ? m_pte[h] : 32'h0;
      e.big = (h >= 0) ? m_big[h] : 1'b0;
      q.push_back(e);
    end
    if (fl) begin
      for (int i = 0; i < N; i++) begin
        bit pg = m_page(i, fa);
        bit sp = !m_pte[i][5] && m_asid[i] == fasid;
        bit k = (!fva && !fas) || (fva && !fas && pg) || (!fva && fas && sp) || (fva && fas && pg && sp);
        if (k) m_val[i] = 0;
      end
    end else if (up) begin
      v = m_victim();
      m_vpn[v] = uvpn; m_asid[v] = uas; m_big[v] = ubig; m_pte[v] = upte; m_val[v] = upte[0];
      m_touch(v);
      h_vpn.push_back(uvpn); h_asid.push_back(uas);
    end
    if (!(up && !fl) && h >= 0) m_touch(h);
  endtask

  task automatic look(input string tag, input bit acc, input logic [8:0] as, input logic [31:0] a);
    cyc(1, tag, acc, as, a, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic upd(input logic [19:0] pn, input logic [8:0] as, input bit big, input logic [31:0] pte);
    cyc(0, "", 0, 0, 0, 1, pn, as, big, pte, 0, 0, 0, 0, 0);
  endtask

  task automatic flush(input bit fva, input bit fas, input logic [31:0] a, input logic [8:0] as);
    cyc(0, "", 0, 0, 0, 0, 0, 0, 0, 0, 1, fva, fas, a, as);
  endtask

  task automatic scan(input string tag);
    for (int i = 0; i < h_vpn.size(); i++) look(tag, 1, h_asid[i], va(h_vpn[i]));
  endtask

  task automatic do_reset();
    @(negedge clk);
    lk_access = 0; up_valid = 0; fl_valid = 0;
    rst_n = 0;
    m_clear();
    @(negedge clk);
    rst_n = 1;
  endtask

  function automatic logic [31:0] mkpte(input int ppn, input logic [7:0] fl);
    return {22'(ppn), 2'b01, fl};
  endfunction

  // Monitor: compares outputs 1 ns after the driving edge.
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      #1;
      while (q.size() > 0) begin
        e = q.pop_front();
        checks++;
        if (lk_hit !== e.hit || (e.hit && (lk_pte !== e.pte || lk_big !== e.big))) begin
          errors++;
          $display("FAIL %s: hit=%0b pte=%h big=%0b expected hit=%0b pte=%h big=%0b",
                   e.tag, lk_hit, lk_pte, lk_big, e.hit, e.pte, e.big);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R1..: done=0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    look("R10 reset empty", 1, 9'd1, va({10'd1, 10'd5}));
    // R3: fill all entries from reset (first victim is entry 0, R10)
    for (int k = 0; k < N; k++)
      upd({10'(k + 1), 10'(k + 5)}, 9'd1, 0, mkpte(32'h100 + k, 8'hC3));
    scan("R2 fill scan");
    look("R1 asid mismatch", 1, 9'd2, va({10'd1, 10'd5}));
    look("R1 strobe low", 0, 9'd1, va({10'd2, 10'd6}));
    look("R1 low half differs", 1, 9'd1, va({10'd3, 10'd9}));
    // R4: hits reshape the tree before the next eviction
    look("R4 touch", 1, 9'd1, va({10'd4, 10'd8}));
    look("R4 touch", 1, 9'd1, va({10'd7, 10'd11}));
    upd({10'd100, 10'd7}, 9'd3, 0, mkpte(32'h200, 8'hE3));
    scan("R4 eviction scan");
    look("R1 global other asid", 1, 9'd5, va({10'd100, 10'd7}));
    upd({10'd200, 10'd0}, 9'd1, 1, mkpte(32'h300, 8'hCB));
    look("R2 superpage", 1, 9'd1, va({10'd200, 10'h3FF}));
    upd({10'd300, 10'd1}, 9'd1, 0, mkpte(32'h301, 8'hC2));
    look("R3 V=0 update", 1, 9'd1, va({10'd300, 10'd1}));
    scan("R4 second scan");
    // R7: asid-only flush
    flush(0, 1, 32'h0, 9'd1);
    scan("R7 asid flush");
    look("R7 global kept", 1, 9'd3, va({10'd100, 10'd7}));
    // R6: address-only flush across asids
    upd({10'd400, 10'd2}, 9'd2, 0, mkpte(32'h400, 8'hC3));
    upd({10'd400, 10'd2}, 9'd4, 0, mkpte(32'h401, 8'hC3));
    upd({10'd401, 10'd2}, 9'd4, 0, mkpte(32'h402, 8'hC3));
    flush(1, 0, va({10'd400, 10'd2}), 9'd0);
    scan("R6 va flush");
    // R8: address and asid flush
    upd({10'd500, 10'd3}, 9'd6, 0, mkpte(32'h500, 8'hC3));
    upd({10'd500, 10'd3}, 9'd7, 0, mkpte(32'h501, 8'hC3));
    upd({10'd501, 10'd3}, 9'd6, 0, mkpte(32'h502, 8'hC3));
    upd({10'd502, 10'd3}, 9'd3, 0, mkpte(32'h503, 8'hE3));
    flush(1, 1, va({10'd500, 10'd3}), 9'd6);
    flush(1, 1, va({10'd502, 10'd3}), 9'd3);
    scan("R8 va+asid flush");
    // R9: flush beats update
    cyc(0, "", 0, 0, 0, 1, {10'd600, 10'd4}, 9'd1, 0, mkpte(32'h600, 8'hC3),
        1, 1, 0, va({10'd777, 10'd0}), 9'd0);
    look("R9 dropped update", 1, 9'd1, va({10'd600, 10'd4}));
    scan("R9 scan");
    // R5: full flush
    flush(0, 0, 32'h0, 9'd0);
    scan("R5 flush all");
    // R10: reset clears entries loaded again
    upd({10'd700, 10'd5}, 9'd1, 0, mkpte(32'h700, 8'hC3));
    look("R10 before reset", 1, 9'd1, va({10'd700, 10'd5}));
    do_reset();
    scan("R10 after reset");
    @(negedge clk);
    lk_access = 0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule